// File: doc/BRIEF.md
# Block-Buffered DMA Bridge

The bridge moves data between a host register port and a byte stream on the SCSI side through a staging buffer that holds one block. The host picks a transfer mode and a direction bit, then loads a block count. In receive mode the bridge fills the buffer from the stream. In send mode it drains the buffer into the stream. Bytes move only in bursts that a periodic service tick grants. A single ownership flag hands the whole buffer to one side at a time: to the stream engine or to the host.

When the engine finishes a block, the buffer passes to the host and the block count drops by one. The host then reads or writes the buffer through a data port, and the buffer passes back to the engine once the host has moved a full block. After the final block the bridge sets an end-of-transfer status bit. If interrupts on end of process are enabled, it also raises an interrupt. A read of the status register clears that interrupt.

Top module: `blk_dma_bridge`

## Requirements
- R1: Host register map, selected by host_addr: 0 is control, 1 is block count, 2 is status (read only), 3 is buffer data. Control bits [1:0] give the mode: 01 is send, 10 is receive, 00 and 11 are off. Control bit 2 is the direction bit, with 1 meaning toward the host. Control bit 3 enables the end-of-process interrupt. Control reads back as written. Status bits are: [0] buffer not ready, [1] end of DMA, [2] interrupt pending, [3] last byte sent, [4] count loaded. All state is zero after reset.
- R2: A block is 128 bytes (BUF_DEPTH). The engine moves bytes at its own pointer. After the 128th byte, the engine pointer and the host pointer both return to 0 and the buffer passes to the host, which clears status bit 0.
- R3: Each service tick accepted while no burst is pending grants at most 64 bytes (BURST_MAX). A tick that arrives while bytes of the earlier grant remain has no effect. A block end cancels any remaining grant.
- R4: Each block end decrements the block count modulo 256. A loaded count of 0 therefore reads 255 after the first block.
- R5: Receive mode moves bytes only while the direction bit is 1, and send mode only while it is 0. On a mismatch, ticks grant nothing: rx_ready and tx_valid stay low.
- R6: The engine moves bytes only while status bit 0 (buffer not ready) is 1. Loading a count sets bit 0 in receive mode and clears it in send mode. After the host has moved 128 bytes through the data port, bit 0 becomes 1 again.
- R7: Writing the block count sets the loaded bit and clears end of DMA, interrupt pending, last byte sent, the interrupt output and both pointers. No bytes move while the loaded bit is 0. The loaded bit clears when the count reaches zero.
- R8: When the final block ends, end of DMA (status bit 1) is set. Interrupt pending (bit 2) and the irq output are set only if control bit 3 is 1.
- R9: If the final block ends in send mode, last byte sent (status bit 3) is also set.
- R10: A status read returns the status before the read, then clears irq and interrupt pending. End of DMA stays set until the next count load.
- R11: Data-port reads are honoured only in receive mode while status bit 0 is 0. Data-port writes are honoured only in send mode while bit 0 is 0. Any other data-port read returns 0, any other write changes nothing, and neither moves the host pointer. The host pointer wraps modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (read side effects) |
| host_addr | input | 2 | Host register select |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (combinational) |
| tick | input | 1 | Service tick, one cycle wide |
| rx_valid | input | 1 | Stream byte offered toward the buffer |
| rx_data | input | DATA_W | Stream byte toward the buffer |
| rx_ready | output | 1 | Bridge accepts a stream byte |
| tx_valid | output | 1 | Bridge offers a buffer byte to the stream |
| tx_data | output | DATA_W | Buffer byte toward the stream |
| tx_ready | input | 1 | Stream accepts the offered byte |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The assertions assume that the host does not assert host_rd and host_wr in the same cycle. They also assume that the host leaves the control register alone while a burst is pending, so the gating seen on rx_ready and tx_valid always follows the mode that was in force when the grant began. The stimulus issues one register access at a time, through tasks that never overlap. It changes the mode only between transfers, draws stream valid, ready and data at random from a fixed seed, and adds directed cases for the mid-burst tick, the direction mismatch, the unloaded count, the count wrap and data-port accesses outside ownership.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
   typedef enum logic [1:0] {
      XFER_OFF  = 2'b00,
      XFER_SEND = 2'b01,
      XFER_RECV = 2'b10,
      XFER_OFFX = 2'b11
   } xfer_mode_e;

   localparam logic [1:0] RA_CTRL   = 2'd0;
   localparam logic [1:0] RA_COUNT  = 2'd1;
   localparam logic [1:0] RA_STATUS = 2'd2;
   localparam logic [1:0] RA_DATA   = 2'd3;

   localparam int CB_DIR = 2;
   localparam int CB_EOP = 3;

   localparam int SB_NRDY   = 0;
   localparam int SB_END    = 1;
   localparam int SB_IRQ    = 2;
   localparam int SB_LAST   = 3;
   localparam int SB_LOADED = 4;
endpackage

// File: rtl/dmab_stage_buf.sv
module dmab_stage_buf #(
   parameter int DATA_W    = 8,
   parameter int BUF_DEPTH = 128,
   localparam int PTR_W    = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PTR_W-1:0]  raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [PTR_W-1:0]  raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DATA_W-1:0] mem [BUF_DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dmab_engine.sv
module dmab_engine #(
   parameter int BUF_DEPTH = 128,
   parameter int BURST_MAX = 64,
   localparam int PTR_W    = $clog2(BUF_DEPTH),
   localparam int BW       = $clog2(BURST_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             enable,
   input  logic             is_recv,
   input  logic             tick,
   input  logic             rx_valid,
   input  logic             tx_ready,
   output logic             rx_ready,
   output logic             tx_valid,
   output logic             step,
   output logic             block_done,
   output logic [PTR_W-1:0] ptr
);
   logic [BW-1:0]    budget_q;
   logic [PTR_W-1:0] ptr_q;
   logic             active;
   logic             grant;

   assign active     = (budget_q != '0) && enable;
   assign rx_ready   = active && is_recv;
   assign tx_valid   = active && !is_recv;
   assign step       = is_recv ? (rx_valid && rx_ready) : (tx_valid && tx_ready);
   assign block_done = step && (ptr_q == PTR_W'(BUF_DEPTH - 1));
   assign grant      = tick && enable && (budget_q == '0);
   assign ptr        = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ptr_q    <= '0;
         budget_q <= '0;
      end else begin
         if (step) ptr_q <= ptr_q + 1'b1;
         if (block_done)  budget_q <= '0;
         else if (step)   budget_q <= budget_q - 1'b1;
         else if (grant)  budget_q <= BW'(BURST_MAX);
      end
   end

   // checker: bytes moved since the last grant never exceed the burst limit
   logic [BW:0] since_q;
   always_ff @(posedge clk) begin
      if (!rst_n || clr)  since_q <= '0;
      else if (grant)     since_q <= '0;
      else if (step)      since_q <= since_q + 1'b1;
   end

   p_burst_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      since_q <= (BW+1)'(BURST_MAX));
endmodule

// File: rtl/dmab_ctl.sv
module dmab_ctl
   import dmab_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int BUF_DEPTH = 128,
   localparam int PTR_W    = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [DATA_W-1:0] buf_rdata,
   input  logic              block_done,
   output logic              eng_enable,
   output logic              is_recv,
   output logic              dir_ok,
   output logic              loaded,
   output logic              eng_owns,
   output logic              load_pulse,
   output logic              host_buf_we,
   output logic [PTR_W-1:0]  host_ptr,
   output logic              irq
);
   logic [DATA_W-1:0] ctrl_q, count_q, status;
   logic              loaded_q, bnr_q, end_q, last_q, irqp_q, irq_q;
   logic [PTR_W-1:0]  hptr_q;
   xfer_mode_e        mode;
   logic              is_send, dir_bit, eop_en;
   logic              wr_ctrl, st_rd, host_rd_ok, host_step, final_blk;

   assign mode       = xfer_mode_e'(ctrl_q[1:0]);
   assign dir_bit    = ctrl_q[CB_DIR];
   assign eop_en     = ctrl_q[CB_EOP];
   assign is_recv    = (mode == XFER_RECV);
   assign is_send    = (mode == XFER_SEND);
   assign dir_ok     = (is_recv && dir_bit) || (is_send && !dir_bit);
   assign eng_enable = dir_ok && loaded_q && bnr_q;

   assign wr_ctrl     = host_wr && (host_addr == RA_CTRL);
   assign load_pulse  = host_wr && (host_addr == RA_COUNT);
   assign st_rd       = host_rd && (host_addr == RA_STATUS);
   assign host_rd_ok  = host_rd && (host_addr == RA_DATA) && !bnr_q && is_recv;
   assign host_buf_we = host_wr && (host_addr == RA_DATA) && !bnr_q && is_send;
   assign host_step   = host_rd_ok || host_buf_we;
   assign final_blk   = block_done && (count_q == DATA_W'(1));

   assign loaded   = loaded_q;
   assign eng_owns = bnr_q;
   assign host_ptr = hptr_q;
   assign irq      = irq_q;

   always_comb begin
      status            = '0;
      status[SB_NRDY]   = bnr_q;
      status[SB_END]    = end_q;
      status[SB_IRQ]    = irqp_q;
      status[SB_LAST]   = last_q;
      status[SB_LOADED] = loaded_q;
   end

   always_comb begin
      case (host_addr)
         RA_CTRL:   host_rdata = ctrl_q;
         RA_COUNT:  host_rdata = count_q;
         RA_STATUS: host_rdata = status;
         default:   host_rdata = (!bnr_q && is_recv) ? buf_rdata : '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         count_q  <= '0;
         loaded_q <= 1'b0;
         bnr_q    <= 1'b0;
         end_q    <= 1'b0;
         last_q   <= 1'b0;
         irqp_q   <= 1'b0;
         irq_q    <= 1'b0;
         hptr_q   <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= host_wdata;
         if (st_rd) begin
            irq_q  <= 1'b0;
            irqp_q <= 1'b0;
         end
         if (load_pulse) begin
            count_q  <= host_wdata;
            loaded_q <= 1'b1;
            end_q    <= 1'b0;
            last_q   <= 1'b0;
            irqp_q   <= 1'b0;
            irq_q    <= 1'b0;
            hptr_q   <= '0;
            bnr_q    <= is_recv;
         end else if (block_done) begin
            hptr_q  <= '0;
            bnr_q   <= 1'b0;
            count_q <= count_q - 1'b1;
            if (final_blk) begin
               loaded_q <= 1'b0;
               end_q    <= 1'b1;
               last_q   <= is_send;
               if (eop_en) begin
                  irqp_q <= 1'b1;
                  irq_q  <= 1'b1;
               end
            end
         end else if (host_step) begin
            hptr_q <= hptr_q + 1'b1;
            if (hptr_q == PTR_W'(BUF_DEPTH - 1)) bnr_q <= 1'b1;
         end
      end
   end

   p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(eop_en));
   p_last_in_send_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(last_q) |-> $past(is_send));
   p_end_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (end_q && !load_pulse) |=> end_q);
   p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |=> (loaded_q && !irq_q && !end_q && hptr_q == '0));
endmodule

// File: rtl/blk_dma_bridge.sv
module blk_dma_bridge #(
   parameter int DATA_W    = 8,
   parameter int BUF_DEPTH = 128,
   parameter int BURST_MAX = 64,
   localparam int PTR_W    = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              tick,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   output logic              irq
);
   if (BUF_DEPTH < 2 || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("BUF_DEPTH must be a power of two of at least 2");
   end
   if (BURST_MAX < 1 || BURST_MAX > BUF_DEPTH) begin : g_bad_burst
      $error("BURST_MAX must lie between 1 and BUF_DEPTH");
   end
   if (DATA_W < 5) begin : g_bad_width
      $error("DATA_W must hold the five status bits");
   end

   logic             eng_enable, is_recv, dir_ok, loaded, eng_owns;
   logic             load_pulse, host_buf_we, step, block_done;
   logic [PTR_W-1:0] eng_ptr, host_ptr;
   logic [DATA_W-1:0] host_buf_data;
   logic             buf_we;
   logic [PTR_W-1:0] buf_waddr;
   logic [DATA_W-1:0] buf_wdata;

   dmab_ctl #(.DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .buf_rdata(host_buf_data), .block_done(block_done),
      .eng_enable(eng_enable), .is_recv(is_recv), .dir_ok(dir_ok),
      .loaded(loaded), .eng_owns(eng_owns), .load_pulse(load_pulse),
      .host_buf_we(host_buf_we), .host_ptr(host_ptr), .irq(irq)
   );

   dmab_engine #(.BUF_DEPTH(BUF_DEPTH), .BURST_MAX(BURST_MAX)) u_eng (
      .clk(clk), .rst_n(rst_n), .clr(load_pulse), .enable(eng_enable),
      .is_recv(is_recv), .tick(tick), .rx_valid(rx_valid), .tx_ready(tx_ready),
      .rx_ready(rx_ready), .tx_valid(tx_valid), .step(step),
      .block_done(block_done), .ptr(eng_ptr)
   );

   assign buf_we    = (step && is_recv) || host_buf_we;
   assign buf_waddr = is_recv ? eng_ptr : host_ptr;
   assign buf_wdata = is_recv ? rx_data : host_wdata;

   dmab_stage_buf #(.DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_buf (
      .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
      .raddr_a(eng_ptr), .rdata_a(tx_data),
      .raddr_b(host_ptr), .rdata_b(host_buf_data)
   );

   p_block_ptrs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      block_done |=> (eng_ptr == '0 && host_ptr == '0 && !eng_owns));
   p_dir_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_ok |-> !(rx_ready || tx_valid));
   p_owner_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_owns |-> !(rx_ready || tx_valid));
   p_need_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded |-> !(rx_ready || tx_valid));
endmodule

// File: tb/tb_blk_dma_bridge.sv
module tb_blk_dma_bridge;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n, host_wr, host_rd, tick, rx_valid, tx_ready;
   logic [1:0] host_addr;
   logic [7:0] host_wdata, host_rdata, rx_data, tx_data;
   logic       rx_ready, tx_valid, irq;

   blk_dma_bridge dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .tick(tick), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [7:0] model [128];
   int mpos;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [7:0] st(bit nr, bit e, bit ip, bit ls, bit ld);
      return {3'b000, ld, ls, ip, e, nr};
   endfunction

   function automatic logic [7:0] ctl(logic [1:0] m, bit d, bit eop);
      return {4'b0000, eop, d, m};
   endfunction

   function automatic int grant_len(int pos);
      return (128 - pos) < 64 ? (128 - pos) : 64;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic rx_run(input int cycles, input int stop_at, output int got);
      got = 0;
      for (int i = 0; i < cycles && got < stop_at; i++) begin
         rx_valid = (($urandom % 4) != 0);
         rx_data  = 8'($urandom);
         #1;
         if (rx_valid && rx_ready) begin
            model[mpos] = rx_data;
            mpos = (mpos + 1) % 128;
            got++;
         end
         @(negedge clk);
      end
      rx_valid = 1'b0;
   endtask

   task automatic tx_run(input int cycles, output int got);
      got = 0;
      for (int i = 0; i < cycles; i++) begin
         tx_ready = (($urandom % 3) != 0);
         #1;
         if (tx_valid && tx_ready) begin
            chk("R2 send byte", tx_data, model[mpos]);
            mpos = (mpos + 1) % 128;
            got++;
         end
         @(negedge clk);
      end
      tx_ready = 1'b0;
   endtask

   task automatic host_drain(input string tag);
      logic [7:0] d;
      for (int i = 0; i < 128; i++) begin
         rd(2'd3, d);
         chk(tag, d, model[i]);
      end
   endtask

   task automatic watch_idle(input int cycles, input string tag);
      int seen;
      seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; tx_ready = 1'b1;
         #1 if (rx_ready || tx_valid) seen++;
      end
      rx_valid = 1'b0; tx_ready = 1'b0;
      chk(tag, seen, 0);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int got;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
      tick = 0; rx_valid = 0; rx_data = 0; tx_ready = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R1)
      #1;
      chk("R1 reset irq", irq, 0);
      chk("R1 reset rx_ready", rx_ready, 0);
      chk("R1 reset tx_valid", tx_valid, 0);
      rd(2'd2, d); chk("R1 reset status", d, st(0,0,0,0,0));
      rd(2'd1, d); chk("R1 reset count", d, 0);

      // receive, two blocks, interrupt enabled
      wr(2'd0, ctl(2'b10, 1, 1));
      rd(2'd0, d); chk("R1 control readback", d, ctl(2'b10, 1, 1));
      wr(2'd1, 8'd2);
      rd(2'd2, d); chk("R6 recv load status", d, st(1,0,0,0,1));
      rd(2'd3, d); chk("R11 read while engine owns", d, 0);
      mpos = 0;
      pulse_tick();
      rx_run(300, 10, got); chk("R3 partial burst", got, 10);
      pulse_tick();
      rx_run(300, 200, got); chk("R3 mid-burst tick ignored", got, 54);
      pulse_tick();
      rx_run(300, 200, got); chk("R3 full burst", got, grant_len(64));
      rd(2'd2, d); chk("R2 block end status", d, st(0,0,0,0,1));
      rd(2'd1, d); chk("R4 count after block", d, 1);
      host_drain("R11 host read block0");
      rd(2'd2, d); chk("R6 host done returns buffer", d, st(1,0,0,0,1));
      mpos = 0;
      pulse_tick(); rx_run(300, 200, got); chk("R3 burst blk1 a", got, 64);
      pulse_tick(); rx_run(300, 200, got); chk("R3 burst blk1 b", got, 64);
      #1 chk("R8 irq raised", irq, 1);
      rd(2'd2, d); chk("R8 final status", d, st(0,1,1,0,0));
      #1 chk("R10 irq cleared by status read", irq, 0);
      rd(2'd2, d); chk("R10 end stays", d, st(0,1,0,0,0));
      host_drain("R11 host read block1");
      rd(2'd2, d); chk("R6 after drain", d, st(1,1,0,0,0));

      // not loaded: engine owns buffer but count done (R7)
      pulse_tick();
      watch_idle(30, "R7 no move when unloaded");

      // direction mismatch (R5)
      wr(2'd0, ctl(2'b10, 0, 0));
      wr(2'd1, 8'd1);
      rd(2'd2, d); chk("R7 load sets loaded", d, st(1,0,0,0,1));
      pulse_tick();
      watch_idle(40, "R5 mismatch no move");
      wr(2'd0, ctl(2'b10, 1, 0));
      mpos = 0;
      pulse_tick(); rx_run(300, 200, got); chk("R5 fixed dir burst a", got, 64);
      pulse_tick(); rx_run(300, 200, got); chk("R5 fixed dir burst b", got, 64);
      rd(2'd2, d); chk("R8 no irq when disabled", d, st(0,1,0,0,0));
      #1 chk("R8 irq output low", irq, 0);
      host_drain("R11 host read block2");

      // send, one block (R6, R9, R11)
      wr(2'd0, ctl(2'b01, 0, 0));
      wr(2'd1, 8'd1);
      rd(2'd2, d); chk("R6 send load status", d, st(0,0,0,0,1));
      pulse_tick();
      watch_idle(20, "R6 send gated while host owns");
      for (int i = 0; i < 128; i++) begin
         model[i] = 8'($urandom);
         wr(2'd3, model[i]);
      end
      rd(2'd2, d); chk("R6 host filled", d, st(1,0,0,0,1));
      wr(2'd3, ~model[0]);
      mpos = 0;
      pulse_tick(); tx_run(300, got); chk("R3 send burst a", got, 64);
      pulse_tick(); tx_run(300, got); chk("R3 send burst b", got, 64);
      rd(2'd2, d); chk("R9 last byte sent", d, st(0,1,0,1,0));
      rd(2'd1, d); chk("R4 send count zero", d, 0);

      // count wrap (R4)
      wr(2'd0, ctl(2'b10, 1, 1));
      wr(2'd1, 8'd0);
      mpos = 0;
      pulse_tick(); rx_run(300, 200, got); chk("R3 wrap burst a", got, 64);
      pulse_tick(); rx_run(300, 200, got); chk("R3 wrap burst b", got, 64);
      rd(2'd1, d); chk("R4 count wraps", d, 255);
      rd(2'd2, d); chk("R7 still loaded", d, st(0,0,0,0,1));
      #1 chk("R8 no irq mid transfer", irq, 0);

      finished = 1;
      summary();
      $finish;
   end
endmodule